// File: doc/BRIEF.md
# Pointer-relative memory move unit

This execution unit carries out two byte operations on a 4096-byte data memory. Both are addressed through a 12-bit pointer register held inside the unit. The first operation is a two-word indexed copy. The first word carries a 7-bit source offset and the second word carries a 7-bit destination offset. Each offset is added to the pointer, with the sum wrapping modulo 4096. The byte found at the source address is then written to the destination address. The second operation is a one-word push. It stores an 8-bit literal at the pointer address and then steps the pointer down by one, which builds a downward-growing software stack.

Every instruction cycle is split into four clock phases, Q1 to Q4, counted by a free-running phase counter. A decoded instruction word is taken at the edge that ends Q4. It executes during the next instruction cycle: Q1 decodes, Q2 forms the address, Q3 latches the data, and Q4 writes. The memory port has a single address bus and a read data path that is valid within the same clock.

Addressing is guarded in two ways. A small set of indirect-access register addresses reads as zero when used as a copy source, and turns the copy into a no-op when used as a copy destination. A second set of control register addresses is refused as a copy destination; this suppresses the write and raises an error pulse.

Top module: `ptrmove_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, the phase output is 0 (Q1), the pointer is 000h and the write enable is low.
- R2: The phase output counts 0,1,2,3 (Q1..Q4) and wraps, advancing by one every clock.
- R3: A copy is the word pair 1110_1011_1sss_ssss followed by a word whose top nibble is 1111, with the destination offset in bits 6:0. The byte read at pointer+s is written to pointer+d during Q4 of the second instruction cycle.
- R4: A push is 1110_1010_kkkk_kkkk. It writes k to the pointer address during Q4 of its instruction cycle, and the pointer is one lower after that cycle.
- R5: When the copy source address is in the indirect list (default FDDh, FDEh, FDFh, FE7h, FEFh), the byte copied is 00h.
- R6: When the copy destination address is in the indirect list, no write takes place, and `copy_nop` pulses during that Q4.
- R7: When the copy destination address is in the forbidden list (default FF9h, FFDh, FFEh, FFFh), no write takes place, and `dest_err` pulses during that Q4.
- R8: Offset addition and pointer decrement both wrap modulo 4096.
- R9: A copy first word followed by a word whose top nibble is not 1111 is dropped without a write, and that following word executes normally. A lone word with top nibble 1111 does nothing.
- R10: The write enable is high only during Q4.
- R11: `ptr_load` replaces the pointer at the next edge and takes priority over a push decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word present, taken at the edge ending Q4 |
| instr_word | input | 16 | Decoded instruction word |
| ptr_load | input | 1 | Load the pointer from `ptr_load_val` |
| ptr_load_val | input | 12 | New pointer value |
| mem_rdata | input | 8 | Read data from memory for `mem_addr` |
| mem_addr | output | 12 | Memory address |
| mem_we | output | 1 | Memory write enable, written at the clock edge |
| mem_wdata | output | 8 | Memory write data |
| q_phase | output | 2 | Current phase, 0..3 for Q1..Q4 |
| ptr_value | output | 12 | Current pointer |
| copy_nop | output | 1 | Copy dropped because the destination is an indirect register |
| dest_err | output | 1 | Copy refused because the destination is a forbidden register |

## Verification
On every cycle the assertions check the following: the phase steps by one, writes occur only in Q4, neither suppression pulse ever coincides with a write, a source byte from an indirect address latches as zero, and the pointer changes only through a load or a push decrement of exactly one. Other behaviour can only be shown by the bench scenarios. These include that the right byte lands at the right wrapped address, that a push stores its literal before the pointer moves, that an orphaned first word is dropped while its successor still runs, and that every expected write or suppression actually happens.

// File: rtl/ptrmove_pkg.sv
package ptrmove_pkg;
  localparam int AW   = 12;
  localparam int DW   = 8;
  localparam int IW   = 16;
  localparam int OFFW = 7;

  typedef enum logic [1:0] {PH_Q1, PH_Q2, PH_Q3, PH_Q4} phase_t;
  typedef enum logic [1:0] {OP_IDLE, OP_COPY_SRC, OP_COPY_DST, OP_PUSH} op_t;

  function automatic logic is_copy_head(input logic [IW-1:0] w);
    return w[15:7] == 9'b1110_1011_1;
  endfunction

  function automatic logic is_copy_tail(input logic [IW-1:0] w);
    return w[15:12] == 4'hF;
  endfunction

  function automatic logic is_push(input logic [IW-1:0] w);
    return w[15:8] == 8'hEA;
  endfunction

  // base plus zero-extended offset, modulo 2**AW
  function automatic logic [AW-1:0] wrap_add(input logic [AW-1:0] base,
                                             input logic [OFFW-1:0] off);
    return base + {{(AW-OFFW){1'b0}}, off};
  endfunction
endpackage

// File: rtl/ptrmove_phase.sv
module ptrmove_phase
  import ptrmove_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_t ph,
  output logic   slot_end
);
  always_ff @(posedge clk) begin
    if (!rst_n) ph <= PH_Q1;
    else        ph <= phase_t'(ph + 2'd1);
  end
  assign slot_end = (ph == PH_Q4);
endmodule

// File: rtl/ptrmove_decode.sv
module ptrmove_decode
  import ptrmove_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_end,
  input  logic          instr_valid,
  input  logic [IW-1:0] instr_word,
  output op_t           op,
  output logic [IW-1:0] ir_word
);
  logic ir_valid;
  logic tail_due;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir_valid <= 1'b0;
      ir_word  <= '0;
      tail_due <= 1'b0;
    end else if (slot_end) begin
      ir_valid <= instr_valid;
      ir_word  <= instr_word;
      tail_due <= (op == OP_COPY_SRC);
    end
  end

  always_comb begin
    op = OP_IDLE;
    if (ir_valid) begin
      if (tail_due && is_copy_tail(ir_word)) op = OP_COPY_DST;
      else if (is_copy_head(ir_word))        op = OP_COPY_SRC;
      else if (is_push(ir_word))             op = OP_PUSH;
    end
  end
endmodule

// File: rtl/ptrmove_guard.sv
module ptrmove_guard #(
  parameter int                 N    = 4,
  parameter int                 AW   = 12,
  parameter logic [N*AW-1:0]    LIST = '0
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  logic [N-1:0] match;
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = (addr == LIST[i*AW +: AW]);
  end
  assign hit = |match;
endmodule

// File: rtl/ptrmove_unit.sv
module ptrmove_unit
  import ptrmove_pkg::*;
#(
  parameter int              N_IND     = 5,
  parameter logic [N_IND*12-1:0] IND_LIST =
    {12'hFEF, 12'hFE7, 12'hFDF, 12'hFDE, 12'hFDD},
  parameter int              N_FORB    = 4,
  parameter logic [N_FORB*12-1:0] FORB_LIST =
    {12'hFF9, 12'hFFD, 12'hFFE, 12'hFFF}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [15:0]   instr_word,
  input  logic          ptr_load,
  input  logic [11:0]   ptr_load_val,
  input  logic [7:0]    mem_rdata,
  output logic [11:0]   mem_addr,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  output logic [1:0]    q_phase,
  output logic [11:0]   ptr_value,
  output logic          copy_nop,
  output logic          dest_err
);
  phase_t        ph;
  logic          slot_end;
  op_t           op;
  logic [IW-1:0] ir_word;
  logic [AW-1:0] ptr;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] hold_q;
  logic          ind_hit, forb_hit;
  logic          src_latch, push_fire, copy_fire;

  ptrmove_phase u_phase (.clk(clk), .rst_n(rst_n), .ph(ph), .slot_end(slot_end));

  ptrmove_decode u_dec (
    .clk(clk), .rst_n(rst_n), .slot_end(slot_end),
    .instr_valid(instr_valid), .instr_word(instr_word),
    .op(op), .ir_word(ir_word)
  );

  // push addresses the pointer itself; both copy words carry the offset in [6:0]
  assign op_addr = (op == OP_PUSH) ? ptr : wrap_add(ptr, ir_word[OFFW-1:0]);

  ptrmove_guard #(.N(N_IND), .AW(AW), .LIST(IND_LIST)) u_ind (
    .addr(op_addr), .hit(ind_hit));
  ptrmove_guard #(.N(N_FORB), .AW(AW), .LIST(FORB_LIST)) u_forb (
    .addr(op_addr), .hit(forb_hit));

  // named internal events
  assign src_latch = (ph == PH_Q3) && (op == OP_COPY_SRC);
  assign push_fire = slot_end && (op == OP_PUSH);
  assign copy_fire = slot_end && (op == OP_COPY_DST);

  always_ff @(posedge clk) begin
    if (!rst_n)         hold_q <= '0;
    else if (src_latch) hold_q <= ind_hit ? '0 : mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         ptr <= '0;
    else if (ptr_load)  ptr <= ptr_load_val;
    else if (push_fire) ptr <= ptr - 1'b1;
  end

  assign copy_nop  = copy_fire && ind_hit;
  assign dest_err  = copy_fire && forb_hit && !ind_hit;
  assign mem_we    = push_fire || (copy_fire && !ind_hit && !forb_hit);
  assign mem_wdata = (op == OP_PUSH) ? ir_word[DW-1:0] : hold_q;
  assign mem_addr  = op_addr;
  assign q_phase   = ph;
  assign ptr_value = ptr;
endmodule

// File: rtl/ptrmove_checker.sv
module ptrmove_checker
  import ptrmove_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input phase_t        ph,
  input op_t           op,
  input logic          mem_we,
  input logic          copy_nop,
  input logic          dest_err,
  input logic          ptr_load,
  input logic [AW-1:0] ptr,
  input logic          ind_hit,
  input logic [DW-1:0] hold_q
);
  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ph == phase_t'($past(ph) + 2'd1)));

  a_r10_write_in_q4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (ph == PH_Q4));

  a_r6_nop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    copy_nop |-> !mem_we);

  a_r7_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    dest_err |-> !mem_we);

  a_r5_zero_source: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_Q3 && op == OP_COPY_SRC && ind_hit) |=> (hold_q == '0));

  a_r4_push_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_Q4 && op == OP_PUSH && !ptr_load) |=> (ptr == $past(ptr) - 1'b1));

  a_r11_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_load && !(ph == PH_Q4 && op == OP_PUSH)) |=> (ptr == $past(ptr)));
endmodule

bind ptrmove_unit ptrmove_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ph(ph), .op(op), .mem_we(mem_we),
  .copy_nop(copy_nop), .dest_err(dest_err), .ptr_load(ptr_load),
  .ptr(ptr), .ind_hit(ind_hit), .hold_q(hold_q)
);

// File: tb/ptrmove_unit_tb_top.sv
module ptrmove_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [15:0] instr_word = '0;
  logic        ptr_load = 1'b0;
  logic [11:0] ptr_load_val = '0;
  logic [7:0]  mem_rdata;
  logic [11:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic [1:0]  q_phase;
  logic [11:0] ptr_value;
  logic        copy_nop, dest_err;

  always #2 clk = ~clk;  // 250 MHz

  ptrmove_unit dut_i (.*);

  // memory model
  logic [7:0] mem [0:4095];
  logic [7:0] exp_mem [0:4095];
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (rst_n && mem_we) mem[mem_addr] <= mem_wdata;

  int checks = 0, fails = 0;
  logic [11:0] exp_ptr = '0;

  typedef struct { int kind; logic [11:0] addr; logic [7:0] data; string req; } item_t;
  item_t sbq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic bit is_ind(input logic [11:0] a);
    return a == 12'hFDD || a == 12'hFDE || a == 12'hFDF || a == 12'hFE7 || a == 12'hFEF;
  endfunction
  function automatic bit is_forb(input logic [11:0] a);
    return a == 12'hFF9 || a == 12'hFFD || a == 12'hFFE || a == 12'hFFF;
  endfunction

  // driver
  task automatic slot(input bit v, input logic [15:0] w);
    @(negedge clk);
    while (q_phase != 2'd3) @(negedge clk);
    instr_valid = v; instr_word = w;
    @(posedge clk); #1;
    instr_valid = 1'b0; instr_word = '0;
  endtask

  task automatic load_ptr(input logic [11:0] p);
    slot(1'b0, 16'h0);  // let the last instruction finish
    @(negedge clk); ptr_load = 1'b1; ptr_load_val = p;
    @(posedge clk); #1; ptr_load = 1'b0;
    exp_ptr = p;
    chk(ptr_value == p, "R11", "pointer after load", ptr_value, p);
  endtask

  task automatic do_push(input logic [7:0] k);
    item_t it;
    it.kind = 0; it.addr = exp_ptr; it.data = k; it.req = "R4";
    sbq.push_back(it);
    exp_mem[exp_ptr] = k;
    exp_ptr = exp_ptr - 12'd1;
    slot(1'b1, {8'hEA, k});
  endtask

  task automatic do_copy(input logic [6:0] s, input logic [6:0] d, input string req);
    item_t it;
    logic [11:0] sa, da;
    logic [7:0]  v;
    sa = exp_ptr + {5'd0, s};
    da = exp_ptr + {5'd0, d};
    v  = is_ind(sa) ? 8'h00 : exp_mem[sa];
    it.addr = da; it.data = v; it.req = req;
    if (is_ind(da))       it.kind = 1;
    else if (is_forb(da)) it.kind = 2;
    else begin it.kind = 0; exp_mem[da] = v; end
    sbq.push_back(it);
    slot(1'b1, {9'b1110_1011_1, s});
    slot(1'b1, {4'hF, 5'b10101, d});
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && (mem_we || copy_nop || dest_err)) begin
      int k;
      k = mem_we ? 0 : (copy_nop ? 1 : 2);
      chk(q_phase == 2'd3, "R10", "event outside Q4", q_phase, 3);
      if (sbq.size() == 0) begin
        chk(1'b0, "R9", "unexpected memory event kind", k, -1);
      end else begin
        item_t e;
        e = sbq.pop_front();
        chk(k == e.kind, e.req, "event kind", k, e.kind);
        chk(mem_addr == e.addr, e.req, "address", mem_addr, e.addr);
        if (e.kind == 0)
          chk(mem_wdata == e.data, e.req, "write data", mem_wdata, e.data);
      end
    end
  end

  bit done = 1'b0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 8'(i) ^ 8'h3C;
      exp_mem[i] = 8'(i) ^ 8'h3C;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(q_phase == 2'd0, "R1", "phase in reset", q_phase, 0);
    chk(ptr_value == 12'h000, "R1", "pointer in reset", ptr_value, 0);
    chk(mem_we == 1'b0, "R1", "write enable in reset", mem_we, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(q_phase == 2'd1, "R1", "phase one clock after reset", q_phase, 1);
    // R2 phase sequence
    for (int i = 0; i < 8; i++) begin
      logic [1:0] p;
      p = q_phase;
      @(negedge clk);
      chk(q_phase == p + 2'd1, "R2", "phase step", q_phase, p + 2'd1);
    end
    // R4 basic push and stack of pushes
    load_ptr(12'h1EC);
    do_push(8'h08);
    do_push(8'hC1);
    do_push(8'h7E);
    slot(1'b0, 16'h0);
    chk(ptr_value == exp_ptr, "R4", "pointer after pushes", ptr_value, exp_ptr);
    chk(mem[12'h1EC] == 8'h08, "R4", "pushed byte", mem[12'h1EC], 8'h08);
    // R3 copies, including bytes just pushed
    load_ptr(12'h1E0);
    do_copy(7'h0C, 7'h40, "R3");
    do_copy(7'h0B, 7'h41, "R3");
    load_ptr(12'h080);
    do_copy(7'h05, 7'h06, "R3");
    do_copy(7'h7F, 7'h00, "R3");
    // R8 wrap of offset sum and of decrement
    load_ptr(12'hFC0);
    do_copy(7'h7F, 7'h50, "R8");
    load_ptr(12'h001);
    do_push(8'hA1);
    do_push(8'hA2);
    do_push(8'hA3);
    slot(1'b0, 16'h0);
    chk(ptr_value == 12'hFFE, "R8", "pointer wrapped below zero", ptr_value, 12'hFFE);
    // R5 source on indirect register
    load_ptr(12'hF80);
    do_copy(7'h6F, 7'h01, "R5");
    do_copy(7'h5D, 7'h02, "R5");
    // R6 destination on indirect register
    do_copy(7'h03, 7'h67, "R6");
    do_copy(7'h03, 7'h5F, "R6");
    // R7 forbidden destinations
    do_copy(7'h04, 7'h7F, "R7");
    do_copy(7'h04, 7'h79, "R7");
    do_copy(7'h04, 7'h7D, "R7");
    // R9 orphaned head, then lone tail
    load_ptr(12'h300);
    slot(1'b1, {9'b1110_1011_1, 7'h10});
    do_push(8'h5B);
    slot(1'b1, 16'hF00A);
    slot(1'b0, 16'h0);
    slot(1'b0, 16'h0);
    chk(ptr_value == 12'h2FF, "R9", "pointer after orphan head", ptr_value, 12'h2FF);
    chk(mem[12'h300] == 8'h5B, "R9", "push after orphan head", mem[12'h300], 8'h5B);
    chk(mem[12'h30A] == exp_mem[12'h30A], "R9", "lone tail left memory",
        mem[12'h30A], exp_mem[12'h30A]);
    // final comparisons
    chk(mem[12'hF81] == 8'h00, "R5", "zero copied from indirect", mem[12'hF81], 0);
    chk(mem[12'hFE7] == exp_mem[12'hFE7], "R6", "indirect dest untouched",
        mem[12'hFE7], exp_mem[12'hFE7]);
    chk(mem[12'hFFF] == exp_mem[12'hFFF], "R7", "forbidden dest untouched",
        mem[12'hFFF], exp_mem[12'hFFF]);
    chk(sbq.size() == 0, "R3", "expected events left over", sbq.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule